// File: doc/BRIEF.md
# Quadword Register Pair Loader

This block executes the memory side of a 128-bit quadword load. It issues two consecutive doubleword reads and delivers the results as two writes to a register file. The caller supplies four things with a single start strobe: a base address, a signed displacement immediate, the even number of the first target register, and an endianness mode bit. The effective address is the base plus the displacement scaled by sixteen. The block reads the doubleword at that address and then the one eight bytes above it.

In big-endian mode the two doublewords go to the even and odd registers unchanged and in address order. In little-endian mode the pairing is swapped and each doubleword has its byte order reversed. If the first target register number is odd, the request is refused: an error pulse is produced and the block does no memory or register activity. A one-cycle completion pulse follows the second register write. Start strobes that arrive while an operation is in flight are dropped.

Top module: `qpair_loader`

## Requirements
- R1: After reset, mem_req_o, rf_wr_en_o, done_o and err_o are all 0.
- R2: For an accepted start, exactly two read requests are made. The first is at EA and the second at EA+8. mem_req_o and mem_addr_o hold steady until mem_ready_i is seen high for the current read.
- R3: With le_mode_i=0, the even register receives the doubleword read at EA and the odd register receives the doubleword read at EA+8, both unmodified.
- R4: With le_mode_i=1, the even register receives the doubleword at EA+8 byte-reversed, and the odd register receives the doubleword at EA byte-reversed. Byte-reversed means byte k (bits 8k+7:8k) moves to byte 7-k.
- R5: An accepted operation makes exactly two write pulses on consecutive cycles. The first targets the given even register and the second targets that number with bit 0 set.
- R6: done_o is high for exactly one cycle, in the cycle directly after the second write pulse.
- R7: A start whose register number has bit 0 set raises err_o for one cycle. It makes no read request and no register write.
- R8: A start asserted while an operation is in progress is ignored. That operation still produces exactly its own two reads and two writes, and no further activity follows.
- R9: EA = base_addr_i + sign_extend(dq_imm_i) * 16, computed modulo 2^64. Negative displacements therefore address below the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a quadword load (sampled only when idle) |
| base_addr_i | input | 64 | Base address |
| dq_imm_i | input | 12 | Signed displacement in 16-byte units |
| pair_reg_i | input | 5 | Even register number of the target pair |
| le_mode_i | input | 1 | 1 = little-endian mode |
| mem_addr_o | output | 64 | Doubleword read address |
| mem_req_o | output | 1 | Read request, held until ready |
| mem_rdata_i | input | 64 | Read data, valid with ready |
| mem_ready_i | input | 1 | Read completion |
| rf_wr_idx_o | output | 5 | Register write index |
| rf_wr_data_o | output | 64 | Register write data |
| rf_wr_en_o | output | 1 | Register write enable |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Odd-register rejection pulse |

## Verification
The memory model returns data that is a distinct hash of each address. A misrouted pair, a wrong address, or a missing or extra byte reversal therefore shows up as a data mismatch rather than an accidental match. Directed cases cover each mode separately, so swapped pairing and a missing reversal are told apart. Further directed cases use negative and extreme displacements to separate sign extension from zero extension, odd register numbers for the reject path, and a second start issued mid-operation. Random operations mix both modes, random register pairs and random ready latency, which exposes any dependence on read timing.

// File: rtl/qpl_pkg.sv
package qpl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_LO,
    ST_READ_HI,
    ST_WRITE,
    ST_DONE
  } qpl_state_e;
endpackage

// File: rtl/qpl_ea.sv
// Effective address: base plus sign-extended displacement scaled by 2**SCALE_LG2.
module qpl_ea #(
  parameter int ADDR_W    = 64,
  parameter int DQ_W      = 12,
  parameter int SCALE_LG2 = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic [ADDR_W-1:0] ea_o
);
  localparam int EXT_W = ADDR_W - DQ_W;

  logic [ADDR_W-1:0] disp_ext;

  assign disp_ext = {{EXT_W{dq_i[DQ_W-1]}}, dq_i} << SCALE_LG2;
  assign ea_o     = base_i + disp_ext;
endmodule

// File: rtl/qpl_swap.sv
// Byte-order reversal of one data word.
module qpl_swap #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  localparam int NBYTES = DATA_W / 8;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign dout_o[8*k +: 8] = din_i[8*(NBYTES-1-k) +: 8];
  end
endmodule

// File: rtl/qpl_data.sv
// Holds the returned doublewords and registers the write data for each write slot.
module qpl_data #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              le_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  input  logic              emit_odd_i,
  output logic [DATA_W-1:0] wr_data_o
);
  logic [DATA_W-1:0] lo_q, hi_q;
  logic [DATA_W-1:0] rdata_rev, lo_rev;

  qpl_swap #(.DATA_W(DATA_W)) u_swap_rd (.din_i(rdata_i), .dout_o(rdata_rev));
  qpl_swap #(.DATA_W(DATA_W)) u_swap_lo (.din_i(lo_q),    .dout_o(lo_rev));

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q      <= '0;
      hi_q      <= '0;
      wr_data_o <= '0;
    end else begin
      if (cap_lo_i) lo_q <= rdata_i;
      if (cap_hi_i) begin
        hi_q      <= rdata_i;
        // even register: low doubleword, or reversed high one in LE mode
        wr_data_o <= le_i ? rdata_rev : lo_q;
      end else if (emit_odd_i) begin
        wr_data_o <= le_i ? lo_rev : hi_q;
      end
    end
  end
endmodule

// File: rtl/qpl_ctrl.sv
// Sequencer: accepts a request, runs two reads, then two register writes.
module qpl_ctrl
  import qpl_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic              le_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic              mem_ready_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              wr_en_o,
  output logic [REG_W-1:0]  wr_idx_o,
  output logic              done_o,
  output logic              err_o,
  output logic              le_o,
  output logic              cap_lo_o,
  output logic              cap_hi_o,
  output logic              emit_odd_o
);
  localparam logic [ADDR_W-1:0] HI_OFF = ADDR_W'(DATA_W / 8);

  qpl_state_e        state_q;
  logic [REG_W-1:0]  reg_q;
  logic [ADDR_W-1:0] ea_q;

  assign le_o       = le_q_w;
  assign cap_lo_o   = (state_q == ST_READ_LO) && mem_ready_i;
  assign cap_hi_o   = (state_q == ST_READ_HI) && mem_ready_i;
  assign emit_odd_o = (state_q == ST_WRITE);

  logic le_q_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      reg_q      <= '0;
      ea_q       <= '0;
      le_q_w     <= 1'b0;
      mem_req_o  <= 1'b0;
      mem_addr_o <= '0;
      wr_en_o    <= 1'b0;
      wr_idx_o   <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      wr_en_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (reg_i[0]) begin
              err_o <= 1'b1;
            end else begin
              reg_q      <= reg_i;
              le_q_w     <= le_i;
              ea_q       <= ea_i;
              mem_req_o  <= 1'b1;
              mem_addr_o <= ea_i;
              state_q    <= ST_READ_LO;
            end
          end
        end
        ST_READ_LO: begin
          if (mem_ready_i) begin
            mem_addr_o <= ea_q + HI_OFF;
            state_q    <= ST_READ_HI;
          end
        end
        ST_READ_HI: begin
          if (mem_ready_i) begin
            mem_req_o <= 1'b0;
            wr_en_o   <= 1'b1;
            wr_idx_o  <= reg_q;
            state_q   <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          wr_en_o  <= 1'b1;
          wr_idx_o <= {reg_q[REG_W-1:1], 1'b1};
          state_q  <= ST_DONE;
        end
        ST_DONE: begin
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: a pending read keeps its request and address until ready
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R5: an even-index write is followed at once by the odd-index write
  p_wr_pair_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && !wr_idx_o[0]) |=> (wr_en_o && wr_idx_o[0]));

  // R6: completion is a single-cycle pulse right after a write
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_after_wr_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(wr_en_o));

  // R7: a rejection never coincides with memory or register activity
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!mem_req_o && !wr_en_o));
endmodule

// File: rtl/qpair_loader.sv
module qpair_loader #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64,
  parameter int REG_W  = 5,
  parameter int DQ_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [DQ_W-1:0]   dq_imm_i,
  input  logic [REG_W-1:0]  pair_reg_i,
  input  logic              le_mode_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_req_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic [REG_W-1:0]  rf_wr_idx_o,
  output logic [DATA_W-1:0] rf_wr_data_o,
  output logic              rf_wr_en_o,
  output logic              done_o,
  output logic              err_o
);
  // displacement unit is the full quadword (two data words)
  localparam int SCALE_LG2 = $clog2(2 * DATA_W / 8);

  logic [ADDR_W-1:0] ea;
  logic              le_q, cap_lo, cap_hi, emit_odd;

  qpl_ea #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .SCALE_LG2(SCALE_LG2)) u_ea (
    .base_i (base_addr_i),
    .dq_i   (dq_imm_i),
    .ea_o   (ea)
  );

  qpl_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .reg_i      (pair_reg_i),
    .le_i       (le_mode_i),
    .ea_i       (ea),
    .mem_ready_i(mem_ready_i),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .wr_en_o    (rf_wr_en_o),
    .wr_idx_o   (rf_wr_idx_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .le_o       (le_q),
    .cap_lo_o   (cap_lo),
    .cap_hi_o   (cap_hi),
    .emit_odd_o (emit_odd)
  );

  qpl_data #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst       (rst),
    .le_i      (le_q),
    .rdata_i   (mem_rdata_i),
    .cap_lo_i  (cap_lo),
    .cap_hi_i  (cap_hi),
    .emit_odd_i(emit_odd),
    .wr_data_o (rf_wr_data_o)
  );

  // R1: outputs are quiet in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!mem_req_o && !rf_wr_en_o && !done_o && !err_o));
endmodule

// File: tb/qpair_loader_bench.sv
module qpair_loader_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [63:0] base_addr_i = '0;
  logic [11:0] dq_imm_i = '0;
  logic [4:0]  pair_reg_i = '0;
  logic        le_mode_i = 1'b0;
  logic [63:0] mem_addr_o;
  logic        mem_req_o;
  logic [63:0] mem_rdata_i = '0;
  logic        mem_ready_i = 1'b0;
  logic [4:0]  rf_wr_idx_o;
  logic [63:0] rf_wr_data_o;
  logic        rf_wr_en_o;
  logic        done_o;
  logic        err_o;

  always #4 clk = ~clk;

  qpair_loader u_qpair_loader (.*);

  int checks = 0, fails = 0;
  bit finished = 0;
  int ready_pct = 50;

  int cyc = 0;
  int rd_cnt, wr_cnt, done_cnt, err_cnt, req_cnt;
  int last_wr_cyc, done_cyc;
  logic [63:0] rd_addr [0:3];
  logic [4:0]  wr_idx  [0:3];
  logic [63:0] wr_dat  [0:3];

  function automatic logic [63:0] memf(input logic [63:0] a);
    return (a * 64'h9E37_79B9_7F4A_7C15) ^ {a[31:0], ~a[63:32]};
  endfunction

  function automatic logic [63:0] brev(input logic [63:0] d);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = d[8*(7-k) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] calc_ea(input logic [63:0] b, input logic [11:0] dq);
    return b + ({{52{dq[11]}}, dq} << 4);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder and monitor, both at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (mem_req_o) begin
      req_cnt++;
      if (($urandom % 100) < ready_pct) begin
        mem_ready_i = 1'b1;
        mem_rdata_i = memf(mem_addr_o);
        if (rd_cnt < 4) rd_addr[rd_cnt] = mem_addr_o;
        rd_cnt++;
      end else begin
        mem_ready_i = 1'b0;
        mem_rdata_i = {$urandom, $urandom};
      end
    end else begin
      mem_ready_i = 1'b0;
      mem_rdata_i = '0;
    end
    if (rf_wr_en_o) begin
      if (wr_cnt < 4) begin
        wr_idx[wr_cnt] = rf_wr_idx_o;
        wr_dat[wr_cnt] = rf_wr_data_o;
      end
      wr_cnt++;
      last_wr_cyc = cyc;
    end
    if (done_o) begin done_cnt++; done_cyc = cyc; end
    if (err_o) err_cnt++;
  end

  task automatic clear_logs();
    rd_cnt = 0; wr_cnt = 0; done_cnt = 0; err_cnt = 0; req_cnt = 0;
    last_wr_cyc = -10; done_cyc = -20;
  endtask

  task automatic run_op(input logic [63:0] b, input logic [11:0] dq, input logic [4:0] rg,
                        input bit le, input bit poke);
    logic [63:0] ea, d0, d1, ev, od;
    @(negedge clk);
    clear_logs();
    base_addr_i = b; dq_imm_i = dq; pair_reg_i = rg; le_mode_i = le; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 300 && done_cnt == 0; i++) begin
      @(negedge clk);
      if (poke && i == 0) begin
        // second request while busy (R8)
        start_i = 1'b1; pair_reg_i = rg ^ 5'd2; base_addr_i = ~b; le_mode_i = ~le;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    ea = calc_ea(b, dq);
    d0 = memf(ea); d1 = memf(ea + 64'd8);
    ev = le ? brev(d1) : d0;
    od = le ? brev(d0) : d1;
    chk(rd_cnt == 2, poke ? "R8 read count" : "R2 read count", 64'(rd_cnt), 64'd2);
    chk(rd_addr[0] == ea, "R2/R9 first address", rd_addr[0], ea);
    chk(rd_addr[1] == ea + 64'd8, "R2 second address", rd_addr[1], ea + 64'd8);
    chk(wr_cnt == 2, poke ? "R8 write count" : "R5 write count", 64'(wr_cnt), 64'd2);
    chk(wr_idx[0] == rg, "R5 even index", 64'(wr_idx[0]), 64'(rg));
    chk(wr_idx[1] == (rg | 5'd1), "R5 odd index", 64'(wr_idx[1]), 64'(rg | 5'd1));
    chk(wr_dat[0] == ev, le ? "R4 even data" : "R3 even data", wr_dat[0], ev);
    chk(wr_dat[1] == od, le ? "R4 odd data" : "R3 odd data", wr_dat[1], od);
    chk(done_cnt == 1, "R6 done count", 64'(done_cnt), 64'd1);
    chk(done_cyc == last_wr_cyc + 1, "R6 done timing", 64'(done_cyc), 64'(last_wr_cyc + 1));
  endtask

  task automatic run_odd(input logic [4:0] rg);
    @(negedge clk);
    clear_logs();
    pair_reg_i = rg | 5'd1; base_addr_i = {$urandom, $urandom}; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(err_cnt == 1, "R7 err pulse", 64'(err_cnt), 64'd1);
    chk(req_cnt == 0, "R7 no read", 64'(req_cnt), 64'd0);
    chk(wr_cnt == 0, "R7 no write", 64'(wr_cnt), 64'd0);
    chk(done_cnt == 0, "R7 no done", 64'(done_cnt), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    clear_logs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(!mem_req_o, "R1 mem_req_o", 64'(mem_req_o), 64'd0);
    chk(!rf_wr_en_o, "R1 rf_wr_en_o", 64'(rf_wr_en_o), 64'd0);
    chk(!done_o, "R1 done_o", 64'(done_o), 64'd0);
    chk(!err_o, "R1 err_o", 64'(err_o), 64'd0);

    ready_pct = 100;
    run_op(64'h0000_1000_0000_0000, 12'd1, 5'd0, 1'b0, 1'b0);   // R3
    run_op(64'h0000_1000_0000_0000, 12'd1, 5'd2, 1'b1, 1'b0);   // R4
    ready_pct = 30;
    run_op(64'h0000_0000_0000_4000, 12'hFFF, 5'd30, 1'b0, 1'b0); // R9 negative
    run_op(64'h0000_0000_0001_0000, 12'h800, 5'd14, 1'b1, 1'b0); // R9 most negative
    run_op(64'hFFFF_FFFF_FFFF_FFF0, 12'h7FF, 5'd4, 1'b0, 1'b0);   // R9 wrap
    run_op(64'h1234_5678_9ABC_DEF0, 12'd3, 5'd8, 1'b1, 1'b1);     // R8 poke
    run_op(64'h0BAD_F00D_0000_0000, 12'd5, 5'd10, 1'b0, 1'b1);    // R8 poke
    run_odd(5'd7);                                                // R7
    run_odd(5'd31);                                               // R7

    for (int n = 0; n < 40; n++) begin
      ready_pct = 20 + ($urandom % 81);
      if (n % 10 == 9) run_odd(5'($urandom));
      else run_op({$urandom, $urandom}, 12'($urandom), 5'($urandom) & 5'h1E,
                  1'($urandom), ($urandom % 4) == 0);
    end

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule